// File: doc/BRIEF.md
# Table-Driven Sequencer

This block is a finite state machine whose entire behaviour lives in a read-only lookup table. On each enabled clock edge the table is read at the address formed by the current state code in the upper bits and the condition inputs in the lower bits. The word that comes back is registered. Its upper bits become the next state code and are fed back to the address. Its lower bits drive auxiliary outputs whose meaning is free for each entry.

The table is computed at elaboration by a function in the package and is never written. Every address has an entry, including every state code that the normal flow never reaches, so recovery from a stray code is set by the table like any other transition. The default size is 32 states, 4 condition bits and 3 auxiliary bits, which gives 512 words of 8 bits. The widths are parameters, so a 2K by 9 table can be built either as 7 state bits with 4 conditions or as 6 state bits with 5 conditions.

All pins are plain control and status pins, so there is no valid/ready handshake and no back-pressure. The condition inputs must already be synchronous to the clock. When their setup time cannot be guaranteed, the caller lowers the enable so that the address register does not sample them.

Top module: `rtfsm_engine`

## Requirements
- R1: A synchronous reset sets the state to 0 and the auxiliary outputs to 0 at the next clock edge. Reset takes effect whatever the enable and condition inputs are.
- R2: The read has one cycle of latency. After an enabled edge, state and aux equal the table word addressed by {state, cond} as they stood before that edge. In that word the state is in the upper STATE_W bits and aux is in the lower AUX_W bits.
- R3: While the enable is low, state and aux keep their values for any condition input.
- R4: From a legal state (code below 24) with cond equal to 0, the state stays the same and aux becomes the low 3 bits of the state.
- R5: From a legal state with cond between 1 and 14, the next state is (state + cond) mod 24 and aux becomes the low 3 bits of (state XOR cond).
- R6: From a legal state with cond equal to 15, the next state is 31 minus the state and aux becomes 3'b101. This is the only path into the unused codes.
- R7: From an unused code (24 to 31), the next state is 0 and aux becomes 3'b111 for every condition value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for the table read and the state update |
| cond | input | COND_W (4) | Condition inputs, synchronous to clk |
| state | output | STATE_W (5) | Registered state code, also fed back to the address |
| aux | output | AUX_W (3) | Registered auxiliary outputs |

## Verification
Two pairs of functions can fall in the same cycle. The first is reset together with a low enable: reset must still clear the state. The bench provokes this by asserting reset with the enable low from a nonzero state, and also with the enable high while in an unused code with cond at all ones, and it expects 0 for state and aux both times. The second is an unused code arriving together with the all-ones condition that would otherwise select the mirror transition: the bench reaches each unused code and sweeps all sixteen condition values, expecting recovery to state 0 with aux 3'b111 every time.

// File: rtl/rtfsm_pkg.sv
package rtfsm_pkg;

  // Number of codes that the normal flow treats as legal states.
  function automatic int unsigned rtfsm_legal(int unsigned sw);
    return (32'd3 << sw) / 32'd4;
  endfunction

  // One table word: next state in the upper bits, aux in the lower bits.
  function automatic int unsigned rtfsm_entry(int unsigned idx, int unsigned sw,
                                              int unsigned cw, int unsigned aw);
    int unsigned s, c, smax, cmax, amask, legal, nxt, a;
    s     = idx >> cw;
    c     = idx & ((32'd1 << cw) - 32'd1);
    smax  = (32'd1 << sw) - 32'd1;
    cmax  = (32'd1 << cw) - 32'd1;
    amask = (32'd1 << aw) - 32'd1;
    legal = rtfsm_legal(sw);
    if (s >= legal) begin
      nxt = 0;
      a   = amask;
    end else if (c == 0) begin
      nxt = s;
      a   = s & amask;
    end else if (c == cmax) begin
      nxt = smax - s;
      a   = 32'd5 & amask;
    end else begin
      nxt = (s + c) % legal;
      a   = (s ^ c) & amask;
    end
    return (nxt << aw) | a;
  endfunction

endpackage

// File: rtl/rtfsm_addr.sv
module rtfsm_addr #(
  parameter int STATE_W = 5,
  parameter int COND_W  = 4,
  localparam int ADDR_W = STATE_W + COND_W
) (
  input  logic [STATE_W-1:0] state_q,
  input  logic [COND_W-1:0]  cond,
  output logic [ADDR_W-1:0]  addr
);
  assign addr = {state_q, cond};
endmodule

// File: rtl/rtfsm_rom.sv
module rtfsm_rom #(
  parameter int STATE_W = 5,
  parameter int COND_W  = 4,
  parameter int AUX_W   = 3,
  localparam int ADDR_W = STATE_W + COND_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = STATE_W + AUX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] contents [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    localparam int unsigned ENT = rtfsm_pkg::rtfsm_entry(g, STATE_W, COND_W, AUX_W);
    assign contents[g] = WORD_W'(ENT);
  end

  always_ff @(posedge clk) begin
    if (rst)     word_q <= '0;
    else if (en) word_q <= contents[addr];
  end
endmodule

// File: rtl/rtfsm_split.sv
module rtfsm_split #(
  parameter int STATE_W = 5,
  parameter int AUX_W   = 3,
  localparam int WORD_W = STATE_W + AUX_W
) (
  input  logic [WORD_W-1:0]  word_q,
  output logic [STATE_W-1:0] state,
  output logic [AUX_W-1:0]   aux
);
  assign state = word_q[WORD_W-1:AUX_W];
  assign aux   = word_q[AUX_W-1:0];
endmodule

// File: rtl/rtfsm_engine.sv
module rtfsm_engine #(
  parameter int STATE_W = 5,
  parameter int COND_W  = 4,
  parameter int AUX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [COND_W-1:0]  cond,
  output logic [STATE_W-1:0] state,
  output logic [AUX_W-1:0]   aux
);
  localparam int ADDR_W = STATE_W + COND_W;
  localparam int WORD_W = STATE_W + AUX_W;

  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word_q;

  rtfsm_addr #(.STATE_W(STATE_W), .COND_W(COND_W)) addr_i (
    .state_q(state), .cond(cond), .addr(addr)
  );

  rtfsm_rom #(.STATE_W(STATE_W), .COND_W(COND_W), .AUX_W(AUX_W)) rom_i (
    .clk(clk), .rst(rst), .en(en), .addr(addr), .word_q(word_q)
  );

  rtfsm_split #(.STATE_W(STATE_W), .AUX_W(AUX_W)) split_i (
    .word_q(word_q), .state(state), .aux(aux)
  );
endmodule

// File: rtl/rtfsm_engine_chk.sv
module rtfsm_engine_chk #(
  parameter int STATE_W = 5,
  parameter int COND_W  = 4,
  parameter int AUX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [COND_W-1:0]  cond,
  input logic [STATE_W-1:0] state,
  input logic [AUX_W-1:0]   aux
);
  localparam logic [STATE_W-1:0] LEGAL_C = STATE_W'(rtfsm_pkg::rtfsm_legal(STATE_W));
  localparam logic [COND_W-1:0]  CMAX_C  = '1;
  localparam logic [AUX_W-1:0]   AMAX_C  = '1;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == '0 && aux == '0)); // R1

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(en)) |-> ($stable(state) && $stable(aux))); // R3

  AST_IDLE_COND_STAYS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(en) && $past(cond) == '0 && $past(state) < LEGAL_C) |-> $stable(state)); // R4

  AST_LEGAL_STAYS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(en) && $past(cond) != CMAX_C && $past(state) < LEGAL_C) |-> (state < LEGAL_C)); // R5

  AST_UNUSED_RECOVERS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(en) && $past(state) >= LEGAL_C) |-> (state == '0 && aux == AMAX_C)); // R7
endmodule

bind rtfsm_engine rtfsm_engine_chk #(.STATE_W(STATE_W), .COND_W(COND_W), .AUX_W(AUX_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .cond(cond), .state(state), .aux(aux)
);

// File: tb/rtfsm_engine_tb_top.sv
module rtfsm_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] cond = 4'd0;
  logic [4:0] state;
  logic [2:0] aux;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rtfsm_engine dut_i (
    .clk(clk), .rst(rst), .en(en), .cond(cond), .state(state), .aux(aux)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected next state and aux, computed from the requirement formulas.
  task automatic model(int s, int c, output int ns, output int na);
    if (s >= 24) begin ns = 0; na = 7; end
    else if (c == 0) begin ns = s; na = s % 8; end
    else if (c == 15) begin ns = 31 - s; na = 5; end
    else begin ns = (s + c) % 24; na = (s ^ c) % 8; end
  endtask

  task automatic step(int c, bit e);
    @(negedge clk);
    rst = 1'b0; cond = 4'(c); en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_reset(bit e, int c);
    @(negedge clk);
    rst = 1'b1; en = e; cond = 4'(c);
    @(posedge clk);
    #1;
  endtask

  task automatic walk(int t);
    if (t == 0) return;
    if (t <= 14) step(t, 1'b1);
    else begin step(14, 1'b1); step(t - 14, 1'b1); end
  endtask

  task automatic goto_state(int t);
    pulse_reset(1'b1, 0);
    if (t >= 24) begin walk(31 - t); step(15, 1'b1); end
    else walk(t);
  endtask

  initial begin
    int ns, na, held_aux;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", state, 0);
    check("R1 reset aux", aux, 0);

    // Sweep every state code against every condition value.
    for (int s = 0; s < 32; s++) begin
      for (int c = 0; c < 16; c++) begin
        goto_state(s);
        check("R2 reach state", state, s);
        model(s, c, ns, na);
        step(c, 1'b1);
        if (s >= 24) begin
          check("R7 next state", state, ns); check("R7 aux", aux, na);
        end else if (c == 0) begin
          check("R4 next state", state, ns); check("R4 aux", aux, na);
        end else if (c == 15) begin
          check("R6 next state", state, ns); check("R6 aux", aux, na);
        end else begin
          check("R5 next state", state, ns); check("R5 aux", aux, na);
        end
      end
    end

    // Enable low holds for every condition value, including one that would recover.
    goto_state(5);
    check("R3 setup aux", aux, 5);
    held_aux = aux;
    for (int c = 0; c < 16; c++) begin
      step(c, 1'b0);
      check("R3 hold state", state, 5);
      check("R3 hold aux", aux, held_aux);
    end
    goto_state(26);
    for (int c = 0; c < 16; c++) begin
      step(c, 1'b0);
      check("R3 hold unused state", state, 26);
      check("R3 hold unused aux", aux, 5);
    end

    // Reset coinciding with enable low, and with an unused code plus all-ones cond.
    goto_state(20);
    pulse_reset(1'b0, 9);
    check("R1 reset with enable low state", state, 0);
    check("R1 reset with enable low aux", aux, 0);
    goto_state(27);
    pulse_reset(1'b1, 15);
    check("R1 reset over recovery state", state, 0);
    check("R1 reset over recovery aux", aux, 0);

    // A chained run checked step by step against the model.
    goto_state(0);
    begin
      int s = 0;
      int seq [8] = '{3, 13, 15, 2, 0, 9, 15, 6};
      foreach (seq[i]) begin
        model(s, seq[i], ns, na);
        step(seq[i], 1'b1);
        check("R2 chained state", state, ns);
        check("R2 chained aux", aux, na);
        s = ns;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule